// File: doc/BRIEF.md
# Multiplexed BCD Display Scanner

The scanner takes an eight-digit packed BCD result and walks through it one digit at a time, starting with the most significant digit (D8) and ending with the least significant digit (D1). It then starts over. For every digit slot it shows three things: the digit's 4-bit BCD value, a one-hot strobe that picks which digit is being driven, and a flag that marks the decimal-point digit. The strobe polarity can be selected, so one build can drive common-anode or common-cathode displays.

The strobe does not turn on when the data changes. It turns on a fixed number of scan-clock cycles later, and it turns off one cycle before the next digit's data appears. This lets an external register capture the BCD value on the strobe's leading edge. Leading-zero suppression affects only a separate blank flag that goes to the segment drivers. The BCD bus always carries the true digit. The position of the decimal point is worked out from the measurement mode and the gate range.

All inputs and outputs are plain control and status pins. The block has no streaming interface, so it takes no back-pressure. The scan runs freely whenever the block is out of reset.

Top module: `disp_scanner`

## Requirements
- R1: After reset the scan shows D8 first and moves down one digit every DWELL clock cycles until it reaches D1. It then wraps back to D8.
- R2: `bcd_out` carries bits [4k-1:4k-4] of `digit_reg` while digit Dk is selected, using 8-4-2-1 weighting.
- R3: Exactly one strobe bit, bit k-1 for digit Dk, is active from cycle LAG to cycle DWELL-2 of that digit's slot. No strobe bit is active in any other cycle. The strobe therefore rises LAG cycles after the data changes and falls one cycle before the next change.
- R4: When `cath_sel`=0 an active strobe bit is 1 and the other bits are 0. When `cath_sel`=1 the levels are inverted: active is 0 and idle is 1.
- R5: `bcd_out` does not depend on `lzb_en`. Blanked digits still show their true value on the BCD bus.
- R6: For mode codes 0 (frequency), 1 (period), 3 (time interval) and 5 (oscillator frequency), with range codes 0 to 3, `dp_out` is high during the slot of digit D(range+2).
- R7: In mode 2 (ratio), `dp_out` marks D(range+1). In mode 4 (unit count), it marks D1 for every range code from 0 to 3.
- R8: Range codes 4 to 7 select the external range, and mode codes 6 and 7 are reserved. In either case `dp_out` stays low for the whole frame.
- R9: `blank_out` is high during the slot of Dk only when all four of these hold: `lzb_en`=1, digits Dk through D8 are all zero, k is above the decimal-point digit, and k is above 1.
- R10: While reset is asserted, the selection holds at D8 with the slot counter at zero, and no strobe bit is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_reg | input | 32 | Packed BCD result; D1 is in bits [3:0] and D8 is in bits [31:28] |
| meas_mode | input | 3 | Measurement mode code |
| range_sel | input | 3 | Gate range code; 0 to 3 are internal ranges and 4 to 7 are external |
| cath_sel | input | 1 | Strobe polarity: 0 gives active-high, 1 gives active-low |
| lzb_en | input | 1 | Enables leading-zero blanking |
| bcd_out | output | 4 | BCD value of the selected digit |
| digit_strobe | output | 8 | One-hot digit drive, with polarity set by cath_sel |
| dp_out | output | 1 | High while the decimal-point digit is selected |
| blank_out | output | 1 | High while the selected digit is to be suppressed |

## Verification
The bench runs a full frame for every mode and range code, both polarities, blanking on and off, and several digit patterns, and it compares every cycle against a model.

It targets these failure modes:
- A strobe that rises together with the data, or falls after the data has changed, would corrupt an externally latched value.
- A decimal point off by one position in ratio or unit-count mode, or one shown on the external range, would misplace the reading by a factor of ten.
- Blanking that leaks onto the BCD bus would zero real digits.
- Blanking that ignores the decimal point would erase the "0" in readings such as "0.5".

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  typedef enum logic [2:0] {
    MODE_FREQ   = 3'd0,
    MODE_PERIOD = 3'd1,
    MODE_RATIO  = 3'd2,
    MODE_TIVL   = 3'd3,
    MODE_UNIT   = 3'd4,
    MODE_OSC    = 3'd5,
    MODE_RSV6   = 3'd6,
    MODE_RSV7   = 3'd7
  } meas_mode_e;

  localparam int unsigned INT_RANGES = 4;
  localparam int unsigned BCD_W      = 4;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned DWELL      = 16,
  parameter int unsigned LAG        = 4,
  localparam int unsigned SEL_W     = $clog2(NUM_DIGITS),
  localparam int unsigned CYC_W     = $clog2(DWELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEL_W-1:0] sel,
  output logic             strobe_on
);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(DWELL - 1);
  localparam logic [CYC_W-1:0] CYC_LAG  = CYC_W'(LAG);
  localparam logic [SEL_W-1:0] SEL_TOP  = SEL_W'(NUM_DIGITS - 1);

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      sel <= SEL_TOP;
    end else if (cyc == CYC_LAST) begin
      cyc <= '0;
      sel <= (sel == '0) ? SEL_TOP : sel - 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  always_comb strobe_on = (cyc >= CYC_LAG) && (cyc < CYC_LAST);

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> ((sel == $past(sel) - 1'b1) ||
                             ($past(sel) == '0 && sel == SEL_TOP))); // R1
  AST_STROBE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $stable(sel)); // R3
  AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !$past(strobe_on)); // R3
endmodule

// File: rtl/dp_locator.sv
module dp_locator
  import disp_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned POS_W     = $clog2(NUM_DIGITS + 1)
) (
  input  logic [2:0]       meas_mode,
  input  logic [2:0]       range_sel,
  output logic [POS_W-1:0] dp_pos
);
  logic             internal_rng;
  logic [POS_W-1:0] rng_ext;

  always_comb begin
    internal_rng = (range_sel < 3'(INT_RANGES));
    rng_ext      = POS_W'(range_sel);
    dp_pos       = '0;
    if (internal_rng) begin
      unique case (meas_mode_e'(meas_mode))
        MODE_FREQ, MODE_OSC, MODE_PERIOD, MODE_TIVL: dp_pos = rng_ext + POS_W'(2);
        MODE_RATIO:                                  dp_pos = rng_ext + POS_W'(1);
        MODE_UNIT:                                   dp_pos = POS_W'(1);
        default:                                     dp_pos = '0;
      endcase
    end
  end
endmodule

// File: rtl/lz_blanker.sv
module lz_blanker #(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned POS_W     = $clog2(NUM_DIGITS + 1)
) (
  input  logic [NUM_DIGITS*4-1:0] digit_reg,
  input  logic [POS_W-1:0]        dp_pos,
  input  logic                    lzb_en,
  output logic [NUM_DIGITS-1:0]   blank_mask
);
  logic [NUM_DIGITS:0] zero_up;
  logic [POS_W-1:0]    floor_pos;

  always_comb floor_pos = (dp_pos == '0) ? POS_W'(1) : dp_pos;
  assign zero_up[NUM_DIGITS] = 1'b1;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    assign zero_up[k] = (digit_reg[4*k +: 4] == 4'd0) && zero_up[k+1];
    assign blank_mask[k] = lzb_en && zero_up[k] && (POS_W'(k + 1) > floor_pos);
  end
endmodule

// File: rtl/disp_scanner.sv
module disp_scanner
  import disp_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned DWELL      = 16,
  parameter int unsigned LAG        = 4,
  localparam int unsigned SEL_W     = $clog2(NUM_DIGITS),
  localparam int unsigned POS_W     = $clog2(NUM_DIGITS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_DIGITS*4-1:0] digit_reg,
  input  logic [2:0]              meas_mode,
  input  logic [2:0]              range_sel,
  input  logic                    cath_sel,
  input  logic                    lzb_en,
  output logic [BCD_W-1:0]        bcd_out,
  output logic [NUM_DIGITS-1:0]   digit_strobe,
  output logic                    dp_out,
  output logic                    blank_out
);
  logic [SEL_W-1:0]      sel;
  logic                  strobe_on;
  logic [POS_W-1:0]      dp_pos;
  logic [NUM_DIGITS-1:0] blank_mask;
  logic [NUM_DIGITS-1:0] drive_hi;

  scan_timer #(.NUM_DIGITS(NUM_DIGITS), .DWELL(DWELL), .LAG(LAG)) u_timer (
    .clk(clk), .rst_n(rst_n), .sel(sel), .strobe_on(strobe_on));

  dp_locator #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .meas_mode(meas_mode), .range_sel(range_sel), .dp_pos(dp_pos));

  lz_blanker #(.NUM_DIGITS(NUM_DIGITS)) u_lzb (
    .digit_reg(digit_reg), .dp_pos(dp_pos), .lzb_en(lzb_en), .blank_mask(blank_mask));

  always_comb begin
    bcd_out      = digit_reg[4*sel +: 4];
    drive_hi     = strobe_on ? (NUM_DIGITS'(1) << sel) : '0;
    digit_strobe = cath_sel ? ~drive_hi : drive_hi;
    dp_out       = (dp_pos == POS_W'(sel) + POS_W'(1));
    blank_out    = blank_mask[sel];
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cath_sel ? ~digit_strobe : digit_strobe)); // R3
  AST_BCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on) && $stable(digit_reg)) |-> $stable(bcd_out)); // R2
  AST_BLANK_NOT_DP: assert property (@(posedge clk) disable iff (!rst_n)
    blank_out |-> !dp_out); // R9
  AST_EXT_NO_DP: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel >= 3'd4) |-> !dp_out); // R8
endmodule

// File: tb/tb_disp_scanner.sv
module tb_disp_scanner;
  localparam int ND = 8;
  localparam int DW = 4;
  localparam int LG = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] digit_reg = '0;
  logic [2:0]  meas_mode = '0;
  logic [2:0]  range_sel = '0;
  logic        cath_sel = 1'b0;
  logic        lzb_en = 1'b0;
  logic [3:0]  bcd_out;
  logic [7:0]  digit_strobe;
  logic        dp_out, blank_out;

  int errors = 0;
  int checks = 0;
  int t = 0;

  always #4 clk = ~clk;

  disp_scanner #(.NUM_DIGITS(ND), .DWELL(DW), .LAG(LG)) dut (
    .clk(clk), .rst_n(rst_n), .digit_reg(digit_reg), .meas_mode(meas_mode),
    .range_sel(range_sel), .cath_sel(cath_sel), .lzb_en(lzb_en),
    .bcd_out(bcd_out), .digit_strobe(digit_strobe), .dp_out(dp_out),
    .blank_out(blank_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0d act=%0h exp=%0h", req, t, act, exp);
    end
  endtask

  function automatic int exp_dp(input int m, input int r);
    if (r > 3) return 0;
    case (m)
      0, 1, 3, 5: return r + 2;
      2:          return r + 1;
      4:          return 1;
      default:    return 0;
    endcase
  endfunction

  task automatic check_cycle();
    int cyc = t % DW;
    int sel = 7 - ((t / DW) % ND);
    int k = sel + 1;
    int dpp = exp_dp(meas_mode, range_sel);
    int flo = (dpp == 0) ? 1 : dpp;
    bit act = (cyc >= LG) && (cyc < DW - 1);
    logic [7:0] sv = act ? (8'd1 << sel) : 8'd0;
    bit allz = 1'b1;
    bit eb;
    if (cath_sel) sv = ~sv;
    for (int j = sel; j < ND; j++) if (digit_reg[4*j +: 4] != 0) allz = 1'b0;
    eb = lzb_en && allz && (k > flo);
    chk(bcd_out == digit_reg[4*sel +: 4], "R1/R2/R5 bcd", bcd_out, digit_reg[4*sel +: 4]);
    chk(digit_strobe == sv, cath_sel ? "R3/R4 strobe" : "R3 strobe", digit_strobe, sv);
    chk(dp_out == (dpp == k),
        (range_sel > 3 || meas_mode > 5) ? "R8 dp" :
        (meas_mode == 2 || meas_mode == 4) ? "R7 dp" : "R6 dp", dp_out, dpp == k);
    chk(blank_out == eb, "R9 blank", blank_out, eb);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] pats [5];
    pats[0] = 32'h0000_0000; pats[1] = 32'h1234_5678; pats[2] = 32'h0000_0500;
    pats[3] = 32'h0009_0000; pats[4] = 32'h0000_0001;
    digit_reg = 32'h9876_5432;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: held in reset, D8 selected, no strobe active
    chk(bcd_out == 4'h9, "R10 reset digit", bcd_out, 9);
    chk(digit_strobe == 8'h00, "R10 reset strobe", digit_strobe, 0);
    cath_sel = 1'b1;
    #1 chk(digit_strobe == 8'hFF, "R10/R4 reset strobe low-active", digit_strobe, 8'hFF);
    cath_sel = 1'b0;
    rst_n = 1'b1;
    t = 0;
    for (int p = 0; p < 5; p++)
      for (int m = 0; m < 8; m++)
        for (int r = 0; r < 8; r++)
          for (int c = 0; c < 2; c++)
            for (int z = 0; z < 2; z++) begin
              digit_reg = pats[p]; meas_mode = 3'(m); range_sel = 3'(r);
              cath_sel = c[0]; lzb_en = z[0];
              #1;
              for (int i = 0; i < DW * ND; i++) begin
                check_cycle();
                @(posedge clk); t++;
                @(negedge clk); #1;
              end
            end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule